// File: doc/BRIEF.md
# Pixel Column Hit Recorder

This block holds the hit record for one logic column of a binary-readout pixel sensor. The column has 42 pixels, split into 7 groups of 6. Each pixel supplies one comparator bit and has its own mask bit. While a bunch train is in progress, every bunch-crossing strobe samples the whole column. Each group that still shows a hit after masking becomes one record. A record holds the surviving 6-bit pattern, the index of the group and a bunch-crossing stamp. Records go into a local memory that is deep enough for a complete train.

When several groups fire in the same crossing, a pending-group register holds them. They are written one per clock, lowest group index first. The stamp counter restarts at each train start and stops at its top value instead of wrapping. If the memory fills, further records from that train are discarded and a sticky overflow bit is raised. That bit is presented alongside the read data.

After the train window closes, the stored records are drained in write order through a slow, word-parallel valid/ready port. This port is meant to be shared by several columns. When the last record has been accepted, the pointers return to zero, the empty flag rises, and the column is ready for the next train.

Top module: `pix_col_recorder`

## Requirements
- R1: After reset, rd_valid_o is low, rd_empty_o is high and rd_overflow_o is low.
- R2: A read word carries the stamp in bits [TS_W-1:0] and the group index (0 to GROUPS-1) in the next GIDX_W bits. The masked 6-bit pattern follows, with pixel 6g+k of group g at pattern bit k. All bits above the pattern read as zero.
- R3: A set mask bit stops that pixel from appearing in any pattern. A group whose only hits are masked produces no record.
- R4: When several groups have hits in one crossing, one record per group is stored, in ascending group index order.
- R5: The first crossing after a train_start pulse is stamped 0. Each later in-window crossing is stamped one higher, and the stamp holds at all ones once it reaches that value.
- R6: A bx_strobe while train_active is low stores nothing.
- R7: rd_valid_o stays low while train_active is high.
- R8: A presented record stays on rd_data_o until it is accepted with rd_ready_i. Records are delivered exactly once each, in the order they were stored.
- R9: Once DEPTH records are stored in a train, further records of that train are dropped. rd_overflow_o then stays high until the next train_start, which clears it.
- R10: rd_empty_o rises after the last stored record is accepted, and records of an earlier train are never delivered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| train_start | input | 1 | One-cycle pulse: clears the stamp, the pointers and the overflow bit |
| train_active | input | 1 | High during the train window; recording only, no readout |
| bx_strobe | input | 1 | Bunch-crossing strobe; samples hit_i and mask_i |
| hit_i | input | GROUPS*GROUP_W | Comparator outputs, group g in bits [6g+5:6g] |
| mask_i | input | GROUPS*GROUP_W | Per-pixel mask, 1 = pixel suppressed |
| rd_valid_o | output | 1 | A stored record is presented |
| rd_ready_i | input | 1 | Consumer accepts the presented record |
| rd_data_o | output | WORD_W | Packed record word |
| rd_overflow_o | output | 1 | Sticky: records of this train were dropped |
| rd_empty_o | output | 1 | All stored records delivered, nothing pending |

## Verification
The bench builds the block with DEPTH=8 and TS_W=4. The other parameters keep their defaults. The 8-entry memory lets a ten-crossing train run past capacity, so the drop and overflow behaviour is exercised without thousands of crossings. The 4-bit stamp reaches its saturation value after 15 empty crossings, so the hold at all ones is checked directly. Readout runs both with a stalling ready pattern and with ready held high.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    // Index of the lowest set bit of a vector (0 when none is set).
    function automatic int unsigned first_set(input logic [31:0] vec);
        int unsigned idx;
        idx = 0;
        for (int i = 31; i >= 0; i--) begin
            if (vec[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/pcr_bx_stamp.sv
module pcr_bx_stamp #(
    parameter int TS_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            active_i,
    input  logic            strobe_i,
    output logic [TS_W-1:0] stamp_o
);
    localparam logic [TS_W-1:0] TS_MAX = '1;

    typedef struct packed {
        logic [TS_W-1:0] ts;
    } stamp_state_t;

    stamp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.ts = '0;
        end else if (strobe_i && active_i && (st_q.ts != TS_MAX)) begin
            st_d.ts = st_q.ts + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stamp_o = st_q.ts;
endmodule

// File: rtl/pcr_group_scan.sv
module pcr_group_scan
    import pcr_pkg::*;
#(
    parameter int GROUPS  = 7,
    parameter int GROUP_W = 6,
    parameter int TS_W    = 13,
    parameter int GIDX_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      active_i,
    input  logic                      strobe_i,
    input  logic [GROUPS*GROUP_W-1:0] hit_i,
    input  logic [GROUPS*GROUP_W-1:0] mask_i,
    input  logic [TS_W-1:0]           stamp_i,
    output logic                      wr_en_o,
    output logic [GROUP_W-1:0]        wr_pat_o,
    output logic [GIDX_W-1:0]         wr_gidx_o,
    output logic [TS_W-1:0]           wr_stamp_o,
    output logic                      busy_o
);
    localparam int NPIX = GROUPS * GROUP_W;

    typedef struct packed {
        logic [NPIX-1:0]   pat;
        logic [GROUPS-1:0] pend;
        logic [TS_W-1:0]   stamp;
    } scan_state_t;

    scan_state_t sc_d, sc_q;

    logic [NPIX-1:0]   masked;
    logic [GROUPS-1:0] grp_any;
    int unsigned       sel;

    assign masked = hit_i & ~mask_i;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_any[g] = |masked[g*GROUP_W +: GROUP_W];
    end

    always_comb begin
        sel = first_set(32'(sc_q.pend));
        sc_d = sc_q;
        if (|sc_q.pend) begin
            sc_d.pend[sel] = 1'b0;
        end
        if (start_i) begin
            sc_d.pend = '0;
        end else if (strobe_i && active_i) begin
            sc_d.pat   = masked;
            sc_d.pend  = grp_any;
            sc_d.stamp = stamp_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= sc_d;
    end

    assign wr_en_o    = |sc_q.pend;
    assign wr_pat_o   = sc_q.pat[sel*GROUP_W +: GROUP_W];
    assign wr_gidx_o  = GIDX_W'(sel);
    assign wr_stamp_o = sc_q.stamp;
    assign busy_o     = |sc_q.pend;
endmodule

// File: rtl/pcr_record_store.sv
module pcr_record_store #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              active_i,
    input  logic              busy_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_word_i,
    output logic              rd_valid_o,
    input  logic              rd_ready_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              rd_overflow_o,
    output logic              rd_empty_o
);
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PTR_W  = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic             ovf;
    } store_state_t;

    store_state_t ss_d, ss_q;

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic              fire;
    logic              wr_ok;

    assign rd_valid_o = !active_i && (ss_q.rd_ptr != ss_q.wr_ptr);
    assign fire       = rd_valid_o && rd_ready_i;
    assign wr_ok      = wr_en_i && !start_i && (ss_q.wr_ptr != FULL);

    always_comb begin
        ss_d = ss_q;
        if (start_i) begin
            ss_d = '0;
        end else begin
            if (wr_en_i) begin
                if (ss_q.wr_ptr == FULL) ss_d.ovf    = 1'b1;
                else                     ss_d.wr_ptr = ss_q.wr_ptr + 1'b1;
            end
            if (fire) begin
                if ((ss_q.rd_ptr + 1'b1 == ss_q.wr_ptr) && !wr_en_i) begin
                    ss_d.rd_ptr = '0;
                    ss_d.wr_ptr = '0;
                end else begin
                    ss_d.rd_ptr = ss_q.rd_ptr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ss_q <= '0;
        else        ss_q <= ss_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[ss_q.wr_ptr[ADDR_W-1:0]] <= wr_word_i;
    end

    assign rd_data_o     = mem_q[ss_q.rd_ptr[ADDR_W-1:0]];
    assign rd_overflow_o = ss_q.ovf;
    assign rd_empty_o    = !active_i && !busy_i && (ss_q.rd_ptr == ss_q.wr_ptr);
endmodule

// File: rtl/pix_col_recorder.sv
module pix_col_recorder #(
    parameter int GROUPS  = 7,
    parameter int GROUP_W = 6,
    parameter int TS_W    = 13,
    parameter int DEPTH   = 64,
    parameter int WORD_W  = 30
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      train_start,
    input  logic                      train_active,
    input  logic                      bx_strobe,
    input  logic [GROUPS*GROUP_W-1:0] hit_i,
    input  logic [GROUPS*GROUP_W-1:0] mask_i,
    output logic                      rd_valid_o,
    input  logic                      rd_ready_i,
    output logic [WORD_W-1:0]         rd_data_o,
    output logic                      rd_overflow_o,
    output logic                      rd_empty_o
);
    localparam int GIDX_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int USED_W = GROUP_W + GIDX_W + TS_W;

    logic [TS_W-1:0]    stamp;
    logic               wr_en;
    logic [GROUP_W-1:0] wr_pat;
    logic [GIDX_W-1:0]  wr_gidx;
    logic [TS_W-1:0]    wr_stamp;
    logic               busy;
    logic [WORD_W-1:0]  wr_word;

    pcr_bx_stamp #(.TS_W(TS_W)) u_stamp (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (train_start),
        .active_i (train_active),
        .strobe_i (bx_strobe),
        .stamp_o  (stamp)
    );

    pcr_group_scan #(
        .GROUPS(GROUPS), .GROUP_W(GROUP_W), .TS_W(TS_W), .GIDX_W(GIDX_W)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (train_start),
        .active_i   (train_active),
        .strobe_i   (bx_strobe),
        .hit_i      (hit_i),
        .mask_i     (mask_i),
        .stamp_i    (stamp),
        .wr_en_o    (wr_en),
        .wr_pat_o   (wr_pat),
        .wr_gidx_o  (wr_gidx),
        .wr_stamp_o (wr_stamp),
        .busy_o     (busy)
    );

    assign wr_word = WORD_W'({wr_pat, wr_gidx, wr_stamp});

    pcr_record_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (train_start),
        .active_i      (train_active),
        .busy_i        (busy),
        .wr_en_i       (wr_en),
        .wr_word_i     (wr_word),
        .rd_valid_o    (rd_valid_o),
        .rd_ready_i    (rd_ready_i),
        .rd_data_o     (rd_data_o),
        .rd_overflow_o (rd_overflow_o),
        .rd_empty_o    (rd_empty_o)
    );

    initial begin
        if (USED_W > WORD_W) $error("record does not fit the output word");
    end
endmodule

// File: rtl/pcr_checker.sv
module pcr_checker #(
    parameter int GROUPS  = 7,
    parameter int GROUP_W = 6,
    parameter int TS_W    = 13,
    parameter int WORD_W  = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              train_start,
    input logic              train_active,
    input logic              rd_valid_o,
    input logic              rd_ready_i,
    input logic [WORD_W-1:0] rd_data_o,
    input logic              rd_overflow_o,
    input logic              rd_empty_o
);
    localparam int GIDX_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int USED_W = GROUP_W + GIDX_W + TS_W;

    // R7
    quiet_in_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
        train_active |-> !rd_valid_o);

    // R8
    hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i && !train_start && !train_active)
        |=> (train_active || (rd_valid_o && $stable(rd_data_o))));

    // R9
    no_overflow_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_overflow_o && !train_start) |=> rd_overflow_o);

    // R10
    empty_excludes_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_empty_o |-> !rd_valid_o);

    // R2
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (rd_data_o[WORD_W-1:USED_W] == '0));

    // R2
    group_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (int'(rd_data_o[TS_W +: GIDX_W]) < GROUPS));
endmodule

bind pix_col_recorder pcr_checker #(
    .GROUPS(GROUPS), .GROUP_W(GROUP_W), .TS_W(TS_W), .WORD_W(WORD_W)
) u_pcr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .train_start   (train_start),
    .train_active  (train_active),
    .rd_valid_o    (rd_valid_o),
    .rd_ready_i    (rd_ready_i),
    .rd_data_o     (rd_data_o),
    .rd_overflow_o (rd_overflow_o),
    .rd_empty_o    (rd_empty_o)
);

// File: tb/test_pix_col_recorder.sv
`timescale 1ns/1ps
module test_pix_col_recorder;
    localparam int GROUPS  = 7;
    localparam int GROUP_W = 6;
    localparam int TS_W    = 4;
    localparam int DEPTH   = 8;
    localparam int WORD_W  = 30;
    localparam int GIDX_W  = 3;
    localparam int NPIX    = GROUPS * GROUP_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic train_start = 1'b0;
    logic train_active = 1'b0;
    logic bx_strobe = 1'b0;
    logic [NPIX-1:0] hit_i = '0;
    logic [NPIX-1:0] mask_i = '0;
    logic rd_valid_o;
    logic rd_ready_i = 1'b0;
    logic [WORD_W-1:0] rd_data_o;
    logic rd_overflow_o;
    logic rd_empty_o;

    always #2.5 clk = ~clk;

    pix_col_recorder #(
        .GROUPS(GROUPS), .GROUP_W(GROUP_W), .TS_W(TS_W), .DEPTH(DEPTH), .WORD_W(WORD_W)
    ) i_pix_col_recorder (
        .clk(clk), .rst_n(rst_n), .train_start(train_start), .train_active(train_active),
        .bx_strobe(bx_strobe), .hit_i(hit_i), .mask_i(mask_i), .rd_valid_o(rd_valid_o),
        .rd_ready_i(rd_ready_i), .rd_data_o(rd_data_o), .rd_overflow_o(rd_overflow_o),
        .rd_empty_o(rd_empty_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [WORD_W-1:0] exp_q[$];
    bit exp_ovf = 1'b0;
    int ts_m = 0;
    int cnt_m = 0;
    bit read_en = 1'b0;
    bit stall_mode = 1'b0;
    int cyc = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] grp(input int g, input logic [5:0] p);
        return p;
    endfunction

    function automatic logic [NPIX-1:0] place(input int g, input logic [5:0] p);
        logic [NPIX-1:0] v;
        v = '0;
        v[g*GROUP_W +: GROUP_W] = p;
        return v;
    endfunction

    // Driver: updates the reference model and pushes expected words.
    task automatic crossing(input logic [NPIX-1:0] hits, input logic [NPIX-1:0] msk);
        logic [NPIX-1:0] m;
        logic [WORD_W-1:0] w;
        if (train_active) begin
            m = hits & ~msk;
            for (int g = 0; g < GROUPS; g++) begin
                if (m[g*GROUP_W +: GROUP_W] != '0) begin
                    if (cnt_m < DEPTH) begin
                        w = '0;
                        w[TS_W-1:0] = TS_W'(ts_m);
                        w[TS_W +: GIDX_W] = GIDX_W'(g);
                        w[TS_W+GIDX_W +: GROUP_W] = m[g*GROUP_W +: GROUP_W];
                        exp_q.push_back(w);
                        cnt_m++;
                    end else begin
                        exp_ovf = 1'b1;
                    end
                end
            end
            if (ts_m != (1 << TS_W) - 1) ts_m++;
        end
        @(negedge clk);
        hit_i = hits; mask_i = msk; bx_strobe = 1'b1;
        @(negedge clk);
        bx_strobe = 1'b0; hit_i = '0; mask_i = '0;
        repeat (GROUPS + 2) @(negedge clk);
    endtask

    task automatic start_train();
        @(negedge clk);
        train_start = 1'b1; train_active = 1'b1;
        @(negedge clk);
        train_start = 1'b0;
        ts_m = 0; cnt_m = 0; exp_ovf = 1'b0;
        check(rd_overflow_o == 1'b0, "R9 overflow cleared by train start", rd_overflow_o, 0);
    endtask

    task automatic drain(input bit stall);
        stall_mode = stall;
        @(negedge clk);
        train_active = 1'b0;
        read_en = 1'b1;
        for (int t = 0; t < 400 && exp_q.size() != 0; t++) @(negedge clk);
        @(negedge clk);
        read_en = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, "R8 all records delivered", exp_q.size(), 0);
        check(rd_empty_o == 1'b1, "R10 empty after last transfer", rd_empty_o, 1);
        check(rd_valid_o == 1'b0, "R10 nothing left to present", rd_valid_o, 0);
    endtask

    // Monitor: drives ready and compares every accepted record.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            rd_ready_i = read_en && (!stall_mode || (cyc % 3 != 1));
            if (rd_ready_i && rd_valid_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 R6 R10 unexpected record", rd_data_o, 0);
                end else begin
                    logic [WORD_W-1:0] e;
                    e = exp_q.pop_front();
                    check(rd_data_o == e, "R2 R4 R5 R8 record word", rd_data_o, e);
                    check(rd_overflow_o == exp_ovf, "R9 overflow with data", rd_overflow_o, exp_ovf);
                end
            end
        end
    end

    initial begin
        #(5ns * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rd_valid_o == 1'b0, "R1 valid after reset", rd_valid_o, 0);
        check(rd_empty_o == 1'b1, "R1 empty after reset", rd_empty_o, 1);
        check(rd_overflow_o == 1'b0, "R1 overflow after reset", rd_overflow_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Train 1: R2 R3 R4 R5 R6 R7
        start_train();
        crossing(place(0, 6'b000001) | place(3, 6'b101010) | place(6, 6'b111111), '0);
        crossing(place(2, 6'b001100) | place(5, 6'b110011),
                 place(2, 6'b001100) | place(5, 6'b010001));
        crossing('0, '0);
        crossing(place(4, 6'b000100), '0);
        check(rd_valid_o == 1'b0, "R7 no readout during train", rd_valid_o, 0);
        check(rd_empty_o == 1'b0, "R7 empty low during train", rd_empty_o, 0);
        @(negedge clk);
        train_active = 1'b0;
        crossing(place(1, 6'b111111), '0);   // R6 outside window
        drain(1'b1);

        // Train 2: R9 overflow with DEPTH=8
        start_train();
        for (int i = 0; i < 10; i++) crossing(place(1, 6'(i + 1)), '0);
        check(exp_ovf == 1'b1, "R9 model expects overflow", exp_ovf, 1);
        drain(1'b1);
        check(rd_overflow_o == 1'b1, "R9 overflow sticky after drain", rd_overflow_o, 1);

        // Train 3: R5 saturation, R9 clear, R10 no replay
        start_train();
        for (int i = 0; i < 17; i++) crossing('0, '0);
        crossing(place(6, 6'b100000) | place(0, 6'b010000), '0);
        drain(1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule